// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is the tag side of a cache with 2^SET_BITS sets of WAYS lines each. Every request carries a byte address. The block splits that address into a tag, a set index and an offset. It then searches the selected set for a valid line whose stored tag matches. It models only tags, valid bits and replacement order. It stores no data and has no write policy or bus logic.

On a hit it reports the matching way. On a miss it chooses a way to evict, writes the new tag there and reports that way. It also increments a saturating miss counter. The eviction rule is picked at run time through `policy_lru`. FIFO evicts the line filled longest ago. LRU evicts the line touched longest ago. Running the same reference stream under each setting, after a reset, lets the two miss counts be compared directly.

Top module: `tag_directory`

## Requirements
- R1: The address splits into three fields: offset in bits [OFF_BITS-1:0], set index in the next SET_BITS bits, and tag in the remaining upper bits. Two addresses that differ only in the offset refer to the same line.
- R2: A request hits only when some way of the indexed set is valid and holds the request's tag. No more than one way can match, and `resp_way` gives that way on a hit.
- R3: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `resp_hit` and `resp_way` are valid while `resp_valid` is high.
- R4: On a miss, the tag is written into the victim way at the same clock edge that registers the response. `resp_way` reports that way, and a repeat of the address on the very next cycle hits.
- R5: When the indexed set has any invalid way, a miss fills the lowest-numbered invalid way. No valid line is evicted in that case.
- R6: With `policy_lru`=0 (FIFO), the victim in a full set is the line filled earliest. Hits do not change this order.
- R7: With `policy_lru`=1 (LRU), the victim in a full set is the line whose most recent hit or fill is oldest. Every hit makes its line the newest.
- R8: With WAYS=1, every miss replaces the single line of the indexed set, and `resp_way` is 0.
- R9: `miss_count` rises by one on each miss response and does not change otherwise. It holds at its all-ones value instead of wrapping.
- R10: Reset clears all valid bits, the replacement order and `miss_count`. After reset `resp_valid` is 0, and the first access to any address misses.
- R11: With WAYS=2 and all references in one set, the tag stream A B C A B C B A B D gives 9 misses under FIFO and 8 under LRU, counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lookup request is present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| policy_lru | input | 1 | Replacement rule: 0 = FIFO, 1 = LRU; change only while idle |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_way | output | WAY_W | Hitting way on a hit, filled way on a miss |
| miss_count | output | CNT_W | Saturating count of misses since reset |

## Verification
The bench targets sets that still contain invalid ways. A design that evicted by age too early would throw out live lines, and the way reported for each fill would then disagree with the bench. It runs FIFO streams full of hits; a design that refreshed order on hits there would pick LRU victims and drift in reported ways and counts. Back-to-back repeats of a just-missed address catch a late install, which would show as a second miss. A 4-bit counter driven well past 15 exposes wrap-around. The two-way reference trace must land on 9 and 8 misses exactly.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

  // Extract w bits of a starting at bit lo.
  function automatic logic [63:0] field_of(input logic [63:0] a,
                                           input int unsigned lo,
                                           input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (a >> lo) & mask;
  endfunction

endpackage

// File: rtl/tdir_lookup.sv
module tdir_lookup #(
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAYS-1:0]  valid_row
);

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [WAYS-1:0]           match_vec;

  genvar w;
  for (w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];

    always_ff @(posedge clk) begin
      if (fill_en && (fill_way == WAY_W'(w))) tags[lk_set] <= lk_tag;
    end

    assign match_vec[w] = valid_q[lk_set][w] && (tags[lk_set] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[lk_set][fill_way] <= 1'b1;
    end
  end

  assign valid_row = valid_q[lk_set];
  assign hit       = |match_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match_vec[i]) hit_way = WAY_W'(i);
    end
  end

  // A tag is only installed on a miss, so it can never appear twice in a set.
  assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/tdir_repl.sv
module tdir_repl #(
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             policy_lru,
  input  logic [SET_W-1:0] acc_set,
  input  logic             hit,
  input  logic [WAY_W-1:0] hit_way,
  input  logic [WAYS-1:0]  valid_row,
  output logic [WAY_W-1:0] victim_way
);

  // Rank per line: 0 = newest, WAYS-1 = oldest. Ranks of a set are a permutation.
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_q;
  logic                                 found_free;
  logic [WAY_W-1:0]                     touch_way;
  logic                                 touch_en;

  always_comb begin
    victim_way = '0;
    found_free = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found_free && !valid_row[i]) begin
        victim_way = WAY_W'(i);
        found_free = 1'b1;
      end
    end
    if (!found_free) begin
      for (int i = 0; i < WAYS; i++) begin
        if (rank_q[acc_set][i] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(i);
      end
    end
  end

  // Fills always refresh; hits refresh only under LRU.
  assign touch_en  = acc_en && (!hit || policy_lru);
  assign touch_way = hit ? hit_way : victim_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int i = 0; i < WAYS; i++)
          rank_q[s][i] <= WAY_W'(WAYS - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == touch_way)
          rank_q[acc_set][i] <= '0;
        else if (rank_q[acc_set][i] < rank_q[acc_set][touch_way])
          rank_q[acc_set][i] <= rank_q[acc_set][i] + 1'b1;
      end
    end
  end

  assert_fifo_hit_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && hit && !policy_lru) |=> $stable(rank_q));

  assert_invalid_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !hit && !(&valid_row)) |-> !valid_row[victim_way]);

endmodule

// File: rtl/tag_directory.sv
module tag_directory
  import tdir_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 2,
  parameter int OFF_BITS = 2,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 32,
  parameter int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              policy_lru,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_next(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic [TAG_W-1:0]    a_tag;
  logic [SET_BITS-1:0] a_set;
  logic                lk_hit;
  logic [WAY_W-1:0]    lk_way;
  logic [WAYS-1:0]     set_valid;
  logic [WAY_W-1:0]    victim_way;
  logic                miss_event;

  assign a_tag = TAG_W'(field_of(64'(req_addr), OFF_BITS + SET_BITS, TAG_W));
  assign a_set = SET_BITS'(field_of(64'(req_addr), OFF_BITS, SET_BITS));
  assign miss_event = req_valid && !lk_hit;

  tdir_lookup #(
    .SETS(SETS), .SET_W(SET_BITS), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_set   (a_set),
    .lk_tag   (a_tag),
    .fill_en  (miss_event),
    .fill_way (victim_way),
    .hit      (lk_hit),
    .hit_way  (lk_way),
    .valid_row(set_valid)
  );

  tdir_repl #(
    .SETS(SETS), .SET_W(SET_BITS), .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (req_valid),
    .policy_lru(policy_lru),
    .acc_set   (a_set),
    .hit       (lk_hit),
    .hit_way   (lk_way),
    .valid_row (set_valid),
    .victim_way(victim_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      miss_count <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_hit <= lk_hit;
        resp_way <= lk_hit ? lk_way : victim_way;
      end
      if (miss_event) miss_count <= sat_next(miss_count);
    end
  end

  assert_miss_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit && ($past(miss_count) != CNT_MAX))
      |-> (miss_count == $past(miss_count) + 1'b1));

  assert_miss_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && !resp_hit) |-> $stable(miss_count));

  assert_miss_count_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(miss_count) == CNT_MAX) |-> (miss_count == CNT_MAX));

endmodule

// File: tb/sim_tag_directory.sv
`timescale 1ns/1ps
module sim_tag_directory;
  localparam int AW = 32;
  localparam int SB = 2;
  localparam int OB = 2;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, policy_lru = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rv0, rh0, rv1, rh1, rv2, rh2;
  logic [0:0] rw0, rw2;
  logic [1:0] rw1;
  logic [31:0] mc0, mc1;
  logic [3:0] mc2;

  always #2.5 clk = ~clk;

  tag_directory #(.ADDR_W(AW), .SET_BITS(SB), .OFF_BITS(OB), .WAYS(2), .CNT_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .policy_lru(policy_lru),
    .resp_valid(rv0), .resp_hit(rh0), .resp_way(rw0), .miss_count(mc0));
  tag_directory #(.ADDR_W(AW), .SET_BITS(SB), .OFF_BITS(OB), .WAYS(4), .CNT_W(32)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .policy_lru(policy_lru),
    .resp_valid(rv1), .resp_hit(rh1), .resp_way(rw1), .miss_count(mc1));
  tag_directory #(.ADDR_W(AW), .SET_BITS(SB), .OFF_BITS(OB), .WAYS(1), .CNT_W(4)) u2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .policy_lru(policy_lru),
    .resp_valid(rv2), .resp_hit(rh2), .resp_way(rw2), .miss_count(mc2));

  int checks = 0;
  int fails  = 0;
  int nways[3] = '{2, 4, 1};
  longint cmax[3] = '{64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'd15};
  bit mv[3][4][4];
  int mt[3][4][4];
  int mf[3][4][4];
  int mu[3][4][4];
  longint mcnt[3];
  int now;
  bit eh[3];
  int ew[3];
  int trace[10] = '{1, 2, 3, 1, 2, 3, 2, 1, 2, 4};

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_resp(input int k, input logic v, input logic h, input int w,
                          input longint c, input string rq);
    checks++;
    if (v !== 1'b1 || h !== eh[k] || w != ew[k] || c != mcnt[k]) begin
      fails++;
      $display("FAIL %s inst%0d: actual valid=%0b hit=%0b way=%0d count=%0d expected valid=1 hit=%0b way=%0d count=%0d",
               rq, k, v, h, w, c, eh[k], ew[k], mcnt[k]);
    end
  endtask

  // Reference model: timestamps of fill and of last touch per line.
  task automatic predict(input int k, input int s, input int t, input bit lru);
    int w = -1;
    now++;
    for (int i = 0; i < nways[k]; i++) if (mv[k][s][i] && mt[k][s][i] == t) w = i;
    if (w >= 0) begin
      eh[k] = 1'b1;
      ew[k] = w;
      mu[k][s][w] = now;
    end else begin
      eh[k] = 1'b0;
      for (int i = nways[k] - 1; i >= 0; i--) if (!mv[k][s][i]) w = i;
      if (w < 0) begin
        w = 0;
        for (int i = 1; i < nways[k]; i++)
          if ((lru ? mu[k][s][i] : mf[k][s][i]) < (lru ? mu[k][s][w] : mf[k][s][w])) w = i;
      end
      ew[k] = w;
      mv[k][s][w] = 1'b1;
      mt[k][s][w] = t;
      mf[k][s][w] = now;
      mu[k][s][w] = now;
      if (mcnt[k] < cmax[k]) mcnt[k]++;
    end
  endtask

  task automatic access(input int t, input int s, input int off, input bit lru, input string rq);
    req_addr   = (32'(t) << (SB + OB)) | (32'(s) << OB) | 32'(off);
    policy_lru = lru;
    req_valid  = 1'b1;
    for (int k = 0; k < 3; k++) predict(k, s, t, lru);
    @(negedge clk);
    chk_resp(0, rv0, rh0, int'(rw0), longint'(mc0), rq);
    chk_resp(1, rv1, rh1, int'(rw1), longint'(mc1), rq);
    chk_resp(2, rv2, rh2, int'(rw2), longint'(mc2), {rq, "/R8"});
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    @(negedge clk);
    chk("R3 resp_valid low after idle cycle", longint'(rv0), 0);
  endtask

  task automatic do_reset(input bit lru);
    req_valid  = 1'b0;
    policy_lru = lru;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      mcnt[k] = 0;
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 4; i++) begin
          mv[k][s][i] = 1'b0; mt[k][s][i] = 0; mf[k][s][i] = 0; mu[k][s][i] = 0;
        end
    end
    now = 0;
    @(negedge clk);
    chk("R10 resp_valid after reset", longint'(rv0), 0);
    chk("R10 miss_count u0 after reset", longint'(mc0), 0);
    chk("R10 miss_count u1 after reset", longint'(mc1), 0);
    chk("R10 miss_count u2 after reset", longint'(mc2), 0);
  endtask

  task automatic random_phase(input bit lru, input int n, input string rq);
    for (int j = 0; j < n; j++) begin
      access($urandom_range(0, 5), $urandom_range(0, 3), $urandom_range(0, 3), lru, rq);
      if ($urandom_range(0, 7) == 0) idle_check();
    end
    req_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    // R1: offset bits do not select a different line
    access(7, 2, 0, 1'b0, "R1 first touch");
    access(7, 2, 3, 1'b0, "R1 same line other offset");
    access(7, 3, 0, 1'b0, "R1 other set index");
    idle_check();
    // R5: fresh set fills invalid ways lowest first; R4: back-to-back repeat hits
    for (int j = 0; j < 4; j++) begin
      access(10 + j, 0, 0, 1'b0, "R5 fill order");
      access(10 + j, 0, 1, 1'b0, "R4 immediate repeat");
    end
    idle_check();
    random_phase(1'b0, 600, "R6 FIFO stream");
    chk("R9 saturated 4-bit counter", longint'(mc2), 15);
    do_reset(1'b1);
    access(3, 1, 0, 1'b1, "R10 first access misses");
    random_phase(1'b1, 600, "R7 LRU stream");
    chk("R9 saturated 4-bit counter", longint'(mc2), 15);
    do_reset(1'b0);
    for (int j = 0; j < 10; j++) access(trace[j], 1, 0, 1'b0, "R11 FIFO trace");
    req_valid = 1'b0;
    chk("R11 FIFO trace misses", longint'(mc0), 9);
    do_reset(1'b1);
    for (int j = 0; j < 10; j++) access(trace[j], 1, 0, 1'b1, "R11 LRU trace");
    req_valid = 1'b0;
    chk("R11 LRU trace misses", longint'(mc0), 8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule